// File: doc/BRIEF.md
# Serial 1101 Sequence Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge. It flags every occurrence of the four-bit sequence 1, 1, 0, 1, with the oldest bit first. A single elaboration-time parameter selects one of two state machines that implement the same detector.

With `USE_MEALY = 0` the block builds a registered-output machine with five states: `IDLE` (nothing matched), `SAW_1`, `SAW_11`, `SAW_110` and `FOUND`. The output is high only in `FOUND`, which the machine enters on the clock edge that samples the closing 1. The flag therefore shows one cycle after that bit.

With `USE_MEALY = 1` the block builds an input-dependent machine with four states: `Z_NONE`, `Z_1`, `Z_11` and `Z_110`. The output rises combinationally while `Z_110` is held and the closing 1 is on the input, so it shows in the same cycle as that bit.

Both machines follow the same transitions on a mismatch:

| State | Input 1 | Input 0 |
|---|---|---|
| nothing matched | `1` | stays |
| `1` | `11` | nothing matched |
| `11` | stays | `110` |
| `110` | match | nothing matched |

A match never overlaps the next one. The input-dependent machine returns to `Z_NONE` on the matching edge. The registered machine leaves `FOUND` for `IDLE` on the next edge whatever the input is, so the bit sampled in `FOUND` is dropped.

Top module: `seq_detect_1101`

## Requirements
- R1: An active-high reset acts asynchronously. It forces the nothing-matched state, and `hit` is 0 during reset and afterwards until a new full sequence arrives.
- R2: Registered variant (`USE_MEALY = 0`): `hit` is high for exactly the one cycle that follows the rising edge sampling the final 1 of 1,1,0,1.
- R3: Registered variant: the bit sampled while in `FOUND` is discarded. The machine goes to `IDLE`, so the stream 1,1,0,1,1,1,0,1 gives one match, not two.
- R4: Input-dependent variant (`USE_MEALY = 1`): `hit` is high while the machine is in `Z_110` and `din` is 1. It is therefore high in the same cycle as the final bit and before the edge that samples it.
- R5: Input-dependent variant: the matching edge leads to `Z_NONE`, and a further match needs four new bits. The stream 1,1,0,1,1,1,0,1 gives two matches.
- R6: On a mismatch each machine falls back to the longest prefix that is still valid. A 1 in `11` keeps `11`, so 1,1,1,1,0,1 is detected. A 0 in `1` or in `110` returns to the nothing-matched state.
- R7: Partial sequences (1, 1,1 and 1,1,0) never raise `hit`, and neither does any stream that lacks the full sequence.
- R8: The parameter `USE_MEALY` selects the variant: 0 gives the five-state registered machine and 1 the four-state input-dependent machine. On an identical stream, the registered flag trails the input-dependent flag by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial data bit, sampled on the rising edge |
| hit | output | 1 | Sequence-detected flag |

## Verification
Both variants run side by side on one stream, and each is compared with a behavioural reference kept in the bench. The reference models the non-overlapping match and the dropped bit after `FOUND`.

A table of fixed 16-bit streams covers several cases:
- back-to-back sequences, which separate R3 from R5;
- runs of ones before the 0, which test the `11` self-loop;
- all-zero and all-one streams, where `hit` must stay low.

A long random stream weighted towards ones checks timing and fallback across every transition. Directed tests then apply reset in the middle of a partial sequence, off any clock edge, and count matches on the overlap streams to confirm the one-cycle lag between the variants.

// File: rtl/seq_detect_1101_pkg.sv
package seq_detect_1101_pkg;

    localparam int unsigned MOORE_ST_W = 3;
    localparam int unsigned MEALY_ST_W = 2;

    typedef enum logic [MOORE_ST_W-1:0] {
        IDLE    = 3'd0,
        SAW_1   = 3'd1,
        SAW_11  = 3'd2,
        SAW_110 = 3'd3,
        FOUND   = 3'd4
    } moore_st_t;

    typedef enum logic [MEALY_ST_W-1:0] {
        Z_NONE = 2'd0,
        Z_1    = 2'd1,
        Z_11   = 2'd2,
        Z_110  = 2'd3
    } mealy_st_t;

endpackage

// File: rtl/seq_detect_1101_moore.sv
module seq_detect_1101_moore
    import seq_detect_1101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    moore_st_t state_q;
    moore_st_t state_d;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic: fall back to the longest valid prefix
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    state_d = din ? SAW_1   : IDLE;
            SAW_1:   state_d = din ? SAW_11  : IDLE;
            SAW_11:  state_d = din ? SAW_11  : SAW_110;
            SAW_110: state_d = din ? FOUND   : IDLE;
            FOUND:   state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    // Output logic: depends on the state only
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            FOUND:   hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    AST_MOORE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R2
    AST_MOORE_AFTER_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(din) && !$past(din, 2) && $past(din, 3) && $past(din, 4))); // R2
    AST_MOORE_DROP_BIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> (state_q == IDLE)); // R3

endmodule

// File: rtl/seq_detect_1101_mealy.sv
module seq_detect_1101_mealy
    import seq_detect_1101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    mealy_st_t state_q;
    mealy_st_t state_d;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= Z_NONE;
        else     state_q <= state_d;
    end

    // Next-state logic: a match restarts from nothing matched
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Z_NONE:  state_d = din ? Z_1  : Z_NONE;
            Z_1:     state_d = din ? Z_11 : Z_NONE;
            Z_11:    state_d = din ? Z_11 : Z_110;
            Z_110:   state_d = Z_NONE;
            default: state_d = Z_NONE;
        endcase
    end

    // Output logic: depends on the state and the present input
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            Z_110:   hit = din;
            default: hit = 1'b0;
        endcase
    end

    AST_MEALY_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (din && !$past(din) && $past(din, 2) && $past(din, 3))); // R4
    AST_MEALY_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R5
    AST_MEALY_RESTART: assert property (@(posedge clk) disable iff (rst)
        hit |=> (state_q == Z_NONE)); // R5

endmodule

// File: rtl/seq_detect_1101.sv
module seq_detect_1101 #(
    parameter bit USE_MEALY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    // R8: the parameter picks one of the two machines
    generate
        if (USE_MEALY) begin : g_mealy
            seq_detect_1101_mealy u_fsm (
                .clk (clk),
                .rst (rst),
                .din (din),
                .hit (hit)
            );
        end else begin : g_moore
            seq_detect_1101_moore u_fsm (
                .clk (clk),
                .rst (rst),
                .din (din),
                .hit (hit)
            );
        end
    endgenerate

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !hit); // R1

endmodule

// File: tb/seq_detect_1101_bench.sv
module seq_detect_1101_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit_moore;
    logic hit_mealy;

    always #10 clk = ~clk; // 50 MHz

    seq_detect_1101 #(.USE_MEALY(1'b0)) u_seq_detect_1101 (
        .clk (clk), .rst (rst), .din (din), .hit (hit_moore)
    );
    seq_detect_1101 #(.USE_MEALY(1'b1)) u_seq_detect_1101_mealy (
        .clk (clk), .rst (rst), .din (din), .hit (hit_mealy)
    );

    localparam int NSTREAM = 8;
    localparam logic [15:0] STREAMS [NSTREAM] = '{
        16'b1101_0000_1101_0000,
        16'b1111_1011_0110_1101,
        16'b1101_1101_1101_1101,
        16'b0110_1001_1010_1101,
        16'b1100_1101_0011_0110,
        16'b1010_1010_1101_1011,
        16'b0000_0000_0000_0000,
        16'b1111_1111_1111_1111
    };

    int n_vec = 0;
    int n_bad = 0;

    // Reference state
    logic [3:0] me_hist = '0;
    int         me_cnt = 0;
    logic [3:0] mo_hist = '0;
    int         mo_cnt = 0;
    logic       mo_exp = 1'b0;
    int         mealy_hits = 0;
    int         moore_hits = 0;

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic would_match(input logic [3:0] h, input int c, input logic b);
        return (c >= 3) && ({h[2:0], b} == 4'b1101);
    endfunction

    task automatic do_reset();
        #3 rst = 1'b1;
        me_cnt = 0; mo_cnt = 0; mo_exp = 1'b0;
        #4;
        chk("R1 registered reset", hit_moore, 1'b0);
        chk("R1 input-dependent reset", hit_mealy, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic b, input string tag);
        logic wm;
        @(negedge clk);
        din = b;
        #2;
        wm = would_match(me_hist, me_cnt, b);
        chk({tag, " input-dependent"}, hit_mealy, wm);
        @(posedge clk);
        if (wm) begin
            me_cnt = 0;
            mealy_hits++;
        end else begin
            me_hist = {me_hist[2:0], b};
            if (me_cnt < 4) me_cnt++;
        end
        if (mo_exp) begin
            mo_exp = 1'b0;
            mo_cnt = 0;
        end else if (would_match(mo_hist, mo_cnt, b)) begin
            mo_exp = 1'b1;
            mo_cnt = 0;
            moore_hits++;
        end else begin
            mo_hist = {mo_hist[2:0], b};
            if (mo_cnt < 4) mo_cnt++;
        end
        #2;
        chk({tag, " registered"}, hit_moore, mo_exp);
    endtask

    task automatic send4(input logic [3:0] v, input string tag);
        for (int i = 3; i >= 0; i--) send(v[i], tag);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();

        // Table walk: R2 R4 R6 R7
        for (int s = 0; s < NSTREAM; s++)
            for (int i = 15; i >= 0; i--)
                send(STREAMS[s][i], "R2/R4/R6/R7 table");

        // Random stream weighted towards ones
        for (int i = 0; i < 3000; i++)
            send(($urandom % 4) != 0, "R2/R4/R6 random");

        // R1: reset in the middle of 1,1,0, off a clock edge
        do_reset();
        send(1'b1, "R7 prefix"); send(1'b1, "R7 prefix"); send(1'b0, "R7 prefix");
        do_reset();
        send(1'b1, "R1 after mid-sequence reset");
        chk("R1 no completion across reset", hit_moore, 1'b0);

        // R3 and R5: back-to-back sequences
        do_reset();
        mealy_hits = 0; moore_hits = 0;
        send4(4'b1101, "R3/R5 overlap");
        send4(4'b1101, "R3/R5 overlap");
        send(1'b0, "R3/R5 overlap");
        chk_int("R3 registered match count", moore_hits, 1);
        chk_int("R5 input-dependent match count", mealy_hits, 2);

        // R6: the 11 self-loop
        do_reset();
        mealy_hits = 0; moore_hits = 0;
        send4(4'b1111, "R6 run of ones");
        send(1'b0, "R6 run of ones");
        send(1'b1, "R6 run of ones");
        send(1'b0, "R6 run of ones");
        chk_int("R6 registered match count", moore_hits, 1);
        chk_int("R6 input-dependent match count", mealy_hits, 1);

        // R8: the one-cycle lag between variants
        do_reset();
        send4(4'b1101, "R8 lag");
        chk("R8 registered high after edge", hit_moore, 1'b1);
        #5;
        chk("R8 input-dependent low after match", hit_mealy, 1'b0);
        send(1'b0, "R8 lag");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule